// File: doc/BRIEF.md
# Carry-Save Multi-Operand Accumulator

The block sums a stream of unsigned operands, one per clock, without ever running a long carry chain during the accumulation itself. The running total is kept as two vectors, a sum vector and a carry vector. Each bit position therefore holds a pair of bits, and the digit value at that position is the number of ones in the pair (0, 1 or 2). Each accepted operand passes through a single row of full adders. As a result, carries move by only one position per addition, and the per-operand logic depth does not depend on the width.

A clear strobe empties the total and prepares the block for a new series. The first operand after a clear is loaded straight into the sum vector with a zero carry vector. Every later operand is merged in by a carry-save step. When the user asks for the result, the two vectors are taken as two ordinary binary numbers and added once by a carry-propagate adder. The registered result appears one cycle later, together with a one-cycle done pulse. The internal width is the operand width plus the ceiling of log2 of the largest supported operand count, so an exact total fits.

Top module: `csa_accum`

## Requirements
- R1: After reset `res_o` is 0 and `done_o` is 0. Reset empties the total in the same way a clear does.
- R2: A cycle with `clr_i` high empties the total. A finish request issued after it, with no operands in between, returns 0.
- R3: The first operand accepted after a clear or reset becomes the whole total. A finish request issued right after a single operand returns that operand, zero-extended.
- R4: `res_o` equals the exact unsigned sum of all operands accepted since the last clear. This holds for any operand values, up to `MAX_OPS` operands of the largest value (`ACCW = OPW + clog2(MAX_OPS)` bits).
- R5: `done_o` is high for exactly the cycle after each cycle in which `fin_i` is high. `res_o` changes only at those points and otherwise holds its value.
- R6: When `clr_i` and `op_vld_i` are both high in the same cycle, the clear wins and the operand is discarded.
- R7: When `fin_i` and `op_vld_i` are both high in the same cycle, the reported result excludes that operand. The operand is still added to the total and shows up in the next result.
- R8: A finish request does not change the total. Back-to-back finish requests with no operand between them report the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| clr_i | input | 1 | Start strobe: empties the running total |
| op_vld_i | input | 1 | Operand on op_data_i is accepted this cycle |
| op_data_i | input | OPW | Unsigned operand |
| fin_i | input | 1 | Finish request: resolve the stored total into a binary result |
| res_o | output | ACCW | Resolved result, held between finish requests |
| done_o | output | 1 | One-cycle pulse marking a new res_o |

## Verification
The bench drives a long run of all-ones operands up to the full supported count. A design that drops the top carry, or that sizes the internal width too small, returns a truncated total there. It also issues a clear and an operand in the same cycle, and a finish and an operand in the same cycle. A wrong priority would leak the operand into the emptied total, or count it in the wrong result. Repeated finish requests and clears between series expose a final adder that disturbs the stored vectors, or a first-operand load that still mixes in stale carry bits. The monitor also flags any done pulse that is not matched by a finish request, and any change of the result outside a done cycle.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Action applied to the stored redundant total in a cycle
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_STEP  = 2'd3
  } csa_act_e;

endpackage

// File: rtl/csa_row.sv
// One row of full adders: folds a third vector into a sum/carry pair.
module csa_row #(
  parameter int W = 22
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] car_o
);

  logic [W-1:0] maj;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_fa
      assign sum_o[g] = a_i[g] ^ b_i[g] ^ c_i[g];
      assign maj[g]   = (a_i[g] & b_i[g]) | (c_i[g] & (a_i[g] ^ b_i[g]));
    end
  endgenerate

  // Carry of position i moves to position i+1; nothing enters position 0
  assign car_o = {maj[W-2:0], 1'b0};

  // The row must preserve the represented value modulo 2^W (R4)
  logic [W-1:0] lhs_chk;
  logic [W-1:0] rhs_chk;
  always_comb begin
    lhs_chk = sum_o + car_o;
    rhs_chk = a_i + b_i + c_i;
    p_row_value_r4: assert (lhs_chk == rhs_chk);
  end

endmodule

// File: rtl/csa_cpa.sv
// Carry-propagate adder used once per finish request.
module csa_cpa #(
  parameter int W = 22
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);

  logic [W:0] cy;
  assign cy[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic gen_b;
      logic prp_b;
      assign gen_b   = x_i[g] & y_i[g];
      assign prp_b   = x_i[g] ^ y_i[g];
      assign s_o[g]  = prp_b ^ cy[g];
      assign cy[g+1] = gen_b | (prp_b & cy[g]);
    end
  endgenerate

endmodule

// File: rtl/csa_accum.sv
module csa_accum
  import csa_pkg::*;
#(
  parameter int OPW     = 16,
  parameter int MAX_OPS = 64,
  localparam int CNTW   = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1,
  localparam int ACCW   = OPW + CNTW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            op_vld_i,
  input  logic [OPW-1:0]  op_data_i,
  input  logic            fin_i,
  output logic [ACCW-1:0] res_o,
  output logic            done_o
);

  // Stored redundant total
  logic [ACCW-1:0] sum_q, sum_d;
  logic [ACCW-1:0] car_q, car_d;
  logic            first_q, first_d;
  logic [ACCW-1:0] res_q, res_d;
  logic            done_q, done_d;
  logic            vec_en;
  logic            res_en;
  csa_act_e        act;

  logic [ACCW-1:0] op_ext;
  logic [ACCW-1:0] row_sum;
  logic [ACCW-1:0] row_car;
  logic [ACCW-1:0] cpa_sum;

  assign op_ext = {{CNTW{1'b0}}, op_data_i};

  csa_row #(.W(ACCW)) u_row (
    .a_i   (sum_q),
    .b_i   (car_q),
    .c_i   (op_ext),
    .sum_o (row_sum),
    .car_o (row_car)
  );

  csa_cpa #(.W(ACCW)) u_cpa (
    .x_i (sum_q),
    .y_i (car_q),
    .s_o (cpa_sum)
  );

  // Action selection: clear beats operand
  always_comb begin
    if (clr_i)         act = ACT_CLEAR;
    else if (op_vld_i) act = first_q ? ACT_LOAD : ACT_STEP;
    else               act = ACT_HOLD;
  end

  // Next state
  always_comb begin
    sum_d   = sum_q;
    car_d   = car_q;
    first_d = first_q;
    unique case (act)
      ACT_CLEAR: begin
        sum_d   = '0;
        car_d   = '0;
        first_d = 1'b1;
      end
      ACT_LOAD: begin
        sum_d   = op_ext;
        car_d   = '0;
        first_d = 1'b0;
      end
      ACT_STEP: begin
        sum_d   = row_sum;
        car_d   = row_car;
        first_d = 1'b0;
      end
      default: ;
    endcase
    vec_en = (act != ACT_HOLD);
    res_en = fin_i;
    res_d  = cpa_sum;
    done_d = fin_i;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      car_q   <= '0;
      first_q <= 1'b1;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (vec_en) begin
        sum_q   <= sum_d;
        car_q   <= car_d;
        first_q <= first_d;
      end
      if (res_en) res_q <= res_d;
      done_q <= done_d;
    end
  end

  assign res_o  = res_q;
  assign done_o = done_q;

  // Assertions
  p_clear_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sum_q == '0) && (car_q == '0));

  p_clear_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && op_vld_i) |=> (sum_q == '0) && first_q);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && op_vld_i && first_q) |=>
      (car_q == '0) && (sum_q == {{CNTW{1'b0}}, $past(op_data_i)}));

  p_carry_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    car_q[0] == 1'b0);

  p_done_follows_fin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |=> done_o);

  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> !done_o);

  p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> $stable(res_o));

  p_fin_keeps_total_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && !clr_i && !op_vld_i) |=> $stable(sum_q) && $stable(car_q));

endmodule

// File: tb/sim_csa_accum.sv
module sim_csa_accum;
  localparam int OPW     = 16;
  localparam int MAX_OPS = 64;
  localparam int ACCW    = OPW + $clog2(MAX_OPS);

  logic            clk;
  logic            rst_n;
  logic            clr_i;
  logic            op_vld_i;
  logic [OPW-1:0]  op_data_i;
  logic            fin_i;
  logic [ACCW-1:0] res_o;
  logic            done_o;

  int checks = 0;
  int errors = 0;

  logic [ACCW-1:0] model;
  logic [ACCW-1:0] expq[$];
  string           tagq[$];
  logic [ACCW-1:0] last_res;
  logic            fin_prev;
  int              cycles = 0;

  csa_accum #(.OPW(OPW), .MAX_OPS(MAX_OPS)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .op_vld_i(op_vld_i),
    .op_data_i(op_data_i), .fin_i(fin_i), .res_o(res_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: one cycle of stimulus, with the expected result pushed on fin
  task automatic cyc(input logic clr, input logic vld, input logic [OPW-1:0] d,
                     input logic fin, input string tag);
    @(negedge clk);
    clr_i = clr; op_vld_i = vld; op_data_i = d; fin_i = fin;
    if (fin) begin expq.push_back(model); tagq.push_back(tag); end
    if (clr) model = '0;
    else if (vld) model = model + {{(ACCW-OPW){1'b0}}, d};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b0, "");
  endtask

  // Monitor: compares results, done timing and result stability
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (done_o !== fin_prev) begin
        checks++; errors++;
        $display("FAIL R5: done_o=%0b expected %0b", done_o, fin_prev);
      end
      if (done_o) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R5: unexpected done, res=%0d expected none", res_o);
        end else begin
          string t;
          logic [ACCW-1:0] e;
          e = expq.pop_front();
          t = tagq.pop_front();
          if (res_o !== e) begin
            errors++;
            $display("FAIL %s: res_o=%0d expected %0d", t, res_o, e);
          end
        end
      end else if (res_o !== last_res) begin
        checks++; errors++;
        $display("FAIL R5: res_o changed to %0d expected %0d", res_o, last_res);
      end
      last_res = res_o;
      fin_prev = fin_i;
    end
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: run not finished, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clr_i = 1'b0; op_vld_i = 1'b0; op_data_i = '0; fin_i = 1'b0;
    model = '0; last_res = '0; fin_prev = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_o !== '0 || done_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: res=%0d done=%0b expected 0 0", res_o, done_o);
    end
    rst_n = 1'b1;

    // R1: reset empties total
    cyc(1'b0, 1'b0, '0, 1'b1, "R1");
    // R3: single operand after reset
    cyc(1'b0, 1'b1, 16'd5, 1'b0, "");
    cyc(1'b0, 1'b0, '0, 1'b1, "R3");
    // R4: several patterns
    cyc(1'b0, 1'b1, 16'hAAAA, 1'b0, "");
    cyc(1'b0, 1'b1, 16'h5555, 1'b0, "");
    cyc(1'b0, 1'b1, 16'h8001, 1'b0, "");
    cyc(1'b0, 1'b1, 16'h00FF, 1'b0, "");
    idle(1);
    cyc(1'b0, 1'b1, 16'h1234, 1'b0, "");
    cyc(1'b0, 1'b0, '0, 1'b1, "R4");
    // R8: repeated finish
    cyc(1'b0, 1'b0, '0, 1'b1, "R8");
    cyc(1'b0, 1'b0, '0, 1'b1, "R8");
    // R2: clear then finish
    cyc(1'b1, 1'b0, '0, 1'b0, "");
    cyc(1'b0, 1'b0, '0, 1'b1, "R2");
    // R3: first operand after clear with stale vectors before
    cyc(1'b0, 1'b1, 16'hFFFF, 1'b0, "");
    cyc(1'b0, 1'b1, 16'hFFFF, 1'b0, "");
    cyc(1'b1, 1'b0, '0, 1'b0, "");
    cyc(1'b0, 1'b1, 16'h0F0F, 1'b0, "");
    cyc(1'b0, 1'b0, '0, 1'b1, "R3");
    // R4 boundary: MAX_OPS operands of the largest value
    cyc(1'b1, 1'b0, '0, 1'b0, "");
    for (int i = 0; i < MAX_OPS; i++) cyc(1'b0, 1'b1, 16'hFFFF, 1'b0, "");
    cyc(1'b0, 1'b0, '0, 1'b1, "R4");
    // R4: varied stream
    cyc(1'b1, 1'b0, '0, 1'b0, "");
    for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1, OPW'(i * 1237 + 99), 1'b0, "");
    cyc(1'b0, 1'b0, '0, 1'b1, "R4");
    // R6: clear and operand together
    cyc(1'b0, 1'b1, 16'd77, 1'b0, "");
    cyc(1'b1, 1'b1, 16'd300, 1'b0, "");
    cyc(1'b0, 1'b0, '0, 1'b1, "R6");
    cyc(1'b0, 1'b1, 16'd9, 1'b0, "");
    cyc(1'b0, 1'b0, '0, 1'b1, "R6");
    // R7: finish and operand together
    cyc(1'b0, 1'b1, 16'd1000, 1'b1, "R7");
    cyc(1'b0, 1'b0, '0, 1'b1, "R7");
    // R5: held finish for two cycles, then quiet
    cyc(1'b0, 1'b1, 16'd3, 1'b0, "");
    cyc(1'b0, 1'b0, '0, 1'b1, "R5");
    cyc(1'b0, 1'b0, '0, 1'b1, "R5");
    idle(4);

    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R5: %0d results missing, expected 0", expq.size());
    end
    finish_run();
  end
endmodule